// File: doc/BRIEF.md
# Coherent Line State Controller

This block holds the coherence state of every way in one set of a snooping cache. Each way carries a tag and three state bits: valid, writable and dirty. A line that is dirty but not writable is an owned line. It still holds the only up-to-date copy, but other caches may read it. The block reacts to two kinds of events, and a caller presents at most one of them in any cycle.

A fill installs a returning line. If the fill tag already sits in a valid way, that way is upgraded in place. Otherwise the line goes into the way named by a round-robin victim pointer. A dirty victim is handed to a one-entry writeback slot, which holds it until the memory side acknowledges it.

A snoop from the bus is checked against the ways and then against the pending writeback. The block works out whether to supply data, whether to keep memory from answering, and whether a copy stays shared. The snoop response comes out a fixed number of cycles later. The line state changes at the clock edge that ends the snoop cycle.

Top module: `coh_line_ctrl`

## Requirements
- R1: A fill with `fill_excl`=1 leaves its way valid, writable and dirty.
- R2: A fill with `fill_excl`=0 leaves its way valid and writable when `fill_shared`=0, and valid only (not writable, not dirty) when `fill_shared`=1.
- R3: A fill whose tag matches no valid way goes to the way at the victim pointer. The pointer starts at way 0 and steps by one modulo NWAYS after each such fill. A fill whose tag matches a valid way rewrites that way, leaves the pointer unchanged and starts no writeback.
- R4: A valid, dirty victim raises `wb_req` in the cycle after the fill, with `wb_tag` equal to the victim tag. `wb_req` stays high until a cycle with `wb_ack`=1. A clean or invalid victim raises no writeback.
- R5: A snoop whose tag matches neither a valid way nor the pending writeback yields a response with supply, inhibit and shared all 0, and leaves all line state unchanged.
- R6: On a line hit, `rsp_supply` is 1 only when the line is dirty and `snp_read`=1. `rsp_inhibit` equals `rsp_supply`. `rsp_shared` is 1 when `snp_inv`=0.
- R7: A hit by a snoop with `snp_read`=1 and `snp_inv`=0 clears only the writable bit. Valid and dirty are kept, so a dirty line becomes owned.
- R8: A hit by a snoop with `snp_inv`=1 clears valid, writable and dirty. Any data supply in its response is decided from the state before the clear.
- R9: A snoop that misses every way but matches the pending writeback tag supplies data and asserts inhibit when `snp_read`=1. It asserts shared when `snp_read`=1 and `snp_excl`=0. With `snp_inv`=1 it drops `wb_req` in the next cycle.
- R10: A snoop presented in cycle c gives `rsp_valid`=1 for exactly cycle c+HIT_LAT, and `rsp_valid`=0 in cycles c+1 to c+HIT_LAT-1.
- R11: After reset every way is invalid, not writable and not dirty, and `wb_req` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Fill event this cycle |
| fill_tag | input | TAG_W | Tag of the filled line |
| fill_excl | input | 1 | Fill was requested with exclusive access |
| fill_shared | input | 1 | Bus shared signal seen with the fill response |
| snp_valid | input | 1 | Snoop event this cycle |
| snp_tag | input | TAG_W | Tag of the snooped line |
| snp_read | input | 1 | Snoop wants to read data |
| snp_inv | input | 1 | Snoop invalidates other copies |
| snp_excl | input | 1 | Snoop requester needs exclusive access |
| wb_ack | input | 1 | Memory side has taken the pending writeback |
| line_valid | output | NWAYS | Valid bit of each way |
| line_writable | output | NWAYS | Writable bit of each way |
| line_dirty | output | NWAYS | Dirty bit of each way |
| wb_req | output | 1 | A writeback is pending |
| wb_tag | output | TAG_W | Tag of the pending writeback |
| rsp_valid | output | 1 | Snoop response strobe |
| rsp_supply | output | 1 | This cache supplies the line data |
| rsp_inhibit | output | 1 | Memory must not respond |
| rsp_shared | output | 1 | Assert the bus shared signal |

## Verification
The bench builds the block with four ways, 8-bit tags and a hit latency of 3. With four ways, a fifth distinct fill wraps the victim pointer and evicts way 0, so the writeback path can be reached. A latency of 3 gives the response pipeline interior stages in which `rsp_valid` must stay low. The bench runs every combination of the read, invalidate and exclusive snoop flags, twice in a row, against each of the three fill outcomes, and again against a pending writeback. Expected values come from a small model of the requirements held in the bench.

// File: rtl/coh_line_pkg.sv
package coh_line_pkg;

   typedef struct packed {
      logic valid;
      logic writable;
      logic dirty;
   } line_st_t;

   typedef struct packed {
      logic supply;
      logic inhibit;
      logic shared;
   } snp_rsp_t;

   localparam int RSP_W = $bits(snp_rsp_t);

endpackage

// File: rtl/coh_victim_ptr.sv
module coh_victim_ptr #(
   parameter int NWAYS = 4,
   localparam int IDX_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);

   generate
      if ((NWAYS & (NWAYS - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk) begin
            if (!rst_n)   ptr <= '0;
            else if (adv) ptr <= ptr + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n) ptr <= '0;
            else if (adv) begin
               if (ptr == IDX_W'(NWAYS - 1)) ptr <= '0;
               else                          ptr <= ptr + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/coh_tag_match.sv
module coh_tag_match #(
   parameter int NWAYS = 4,
   parameter int TAG_W = 8,
   localparam int IDX_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
   input  logic [NWAYS-1:0]            way_valid,
   input  logic [NWAYS-1:0][TAG_W-1:0] way_tag,
   input  logic [TAG_W-1:0]            key,
   output logic                        hit,
   output logic [IDX_W-1:0]            idx
);

   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = NWAYS - 1; i >= 0; i--) begin
         if (way_valid[i] && (way_tag[i] == key)) begin
            hit = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/coh_rsp_delay.sv
module coh_rsp_delay #(
   parameter int LAT = 2,
   parameter int W   = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data
);

   logic [LAT-1:0]        v_q;
   logic [LAT-1:0][W-1:0] d_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= '0;
         d_q <= '0;
      end else begin
         v_q[0] <= in_valid;
         d_q[0] <= in_valid ? in_data : '0;
         for (int i = 1; i < LAT; i++) begin
            v_q[i] <= v_q[i-1];
            d_q[i] <= d_q[i-1];
         end
      end
   end

   assign out_valid = v_q[LAT-1];
   assign out_data  = d_q[LAT-1];

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
   import coh_line_pkg::*;
#(
   parameter int NWAYS   = 4,
   parameter int TAG_W   = 8,
   parameter int HIT_LAT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_valid,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             fill_excl,
   input  logic             fill_shared,
   input  logic             snp_valid,
   input  logic [TAG_W-1:0] snp_tag,
   input  logic             snp_read,
   input  logic             snp_inv,
   input  logic             snp_excl,
   input  logic             wb_ack,
   output logic [NWAYS-1:0] line_valid,
   output logic [NWAYS-1:0] line_writable,
   output logic [NWAYS-1:0] line_dirty,
   output logic             wb_req,
   output logic [TAG_W-1:0] wb_tag,
   output logic             rsp_valid,
   output logic             rsp_supply,
   output logic             rsp_inhibit,
   output logic             rsp_shared
);

   localparam int IDX_W = (NWAYS > 1) ? $clog2(NWAYS) : 1;

   generate
      if (NWAYS < 2)   begin : g_bad_ways  $error("NWAYS must be at least 2");   end
      if (TAG_W < 1)   begin : g_bad_tag   $error("TAG_W must be at least 1");   end
      if (HIT_LAT < 1) begin : g_bad_lat   $error("HIT_LAT must be at least 1"); end
   endgenerate

   line_st_t                  st_q [NWAYS];
   logic [NWAYS-1:0][TAG_W-1:0] tag_q;
   logic                      wb_req_q;
   logic [TAG_W-1:0]          wb_tag_q;

   always_comb begin
      for (int i = 0; i < NWAYS; i++) begin
         line_valid[i]    = st_q[i].valid;
         line_writable[i] = st_q[i].writable;
         line_dirty[i]    = st_q[i].dirty;
      end
   end

   // fill side
   logic             f_hit;
   logic [IDX_W-1:0] f_idx;
   logic [IDX_W-1:0] vptr;
   logic [IDX_W-1:0] fill_way;
   logic             fill_go;
   logic             wb_launch;
   line_st_t         fill_st;

   coh_tag_match #(.NWAYS(NWAYS), .TAG_W(TAG_W)) u_fill_match (
      .way_valid (line_valid),
      .way_tag   (tag_q),
      .key       (fill_tag),
      .hit       (f_hit),
      .idx       (f_idx)
   );

   coh_victim_ptr #(.NWAYS(NWAYS)) u_vptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (fill_go && !f_hit),
      .ptr   (vptr)
   );

   always_comb begin
      fill_go   = fill_valid && !snp_valid;
      fill_way  = f_hit ? f_idx : vptr;
      wb_launch = fill_go && !f_hit && st_q[vptr].valid && st_q[vptr].dirty;
      if (fill_excl)        fill_st = '{valid: 1'b1, writable: 1'b1, dirty: 1'b1};
      else if (!fill_shared) fill_st = '{valid: 1'b1, writable: 1'b1, dirty: 1'b0};
      else                  fill_st = '{valid: 1'b1, writable: 1'b0, dirty: 1'b0};
   end

   // snoop side
   logic             s_hit;
   logic [IDX_W-1:0] s_idx;
   logic             wb_hit;
   snp_rsp_t         s_rsp;
   line_st_t         s_cur;

   coh_tag_match #(.NWAYS(NWAYS), .TAG_W(TAG_W)) u_snp_match (
      .way_valid (line_valid),
      .way_tag   (tag_q),
      .key       (snp_tag),
      .hit       (s_hit),
      .idx       (s_idx)
   );

   always_comb begin
      s_cur  = st_q[s_idx];
      wb_hit = !s_hit && wb_req_q && (wb_tag_q == snp_tag);
      s_rsp  = '0;
      if (s_hit) begin
         s_rsp.supply  = s_cur.dirty && snp_read;
         s_rsp.inhibit = s_cur.dirty && snp_read;
         s_rsp.shared  = !snp_inv;
      end else if (wb_hit) begin
         s_rsp.supply  = snp_read;
         s_rsp.inhibit = snp_read;
         s_rsp.shared  = snp_read && !snp_excl;
      end
   end

   // state update
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NWAYS; i++) st_q[i] <= '0;
         tag_q    <= '0;
         wb_req_q <= 1'b0;
         wb_tag_q <= '0;
      end else begin
         if (snp_valid && s_hit) begin
            if (snp_inv)       st_q[s_idx]          <= '0;
            else if (snp_read) st_q[s_idx].writable <= 1'b0;
         end else if (fill_go) begin
            st_q[fill_way]  <= fill_st;
            tag_q[fill_way] <= fill_tag;
         end

         if (wb_launch) begin
            wb_req_q <= 1'b1;
            wb_tag_q <= tag_q[vptr];
         end else if (snp_valid && wb_hit && snp_inv) begin
            wb_req_q <= 1'b0;
         end else if (wb_ack) begin
            wb_req_q <= 1'b0;
         end
      end
   end

   assign wb_req = wb_req_q;
   assign wb_tag = wb_tag_q;

   // response pipeline
   snp_rsp_t out_rsp;

   coh_rsp_delay #(.LAT(HIT_LAT), .W(RSP_W)) u_rsp_dly (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (snp_valid),
      .in_data   (s_rsp),
      .out_valid (rsp_valid),
      .out_data  (out_rsp)
   );

   assign rsp_supply  = out_rsp.supply;
   assign rsp_inhibit = out_rsp.inhibit;
   assign rsp_shared  = out_rsp.shared;

endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk #(
   parameter int NWAYS = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fill_valid,
   input logic             fill_excl,
   input logic             fill_shared,
   input logic             snp_valid,
   input logic             wb_req,
   input logic             wb_ack,
   input logic [NWAYS-1:0] line_valid,
   input logic [NWAYS-1:0] line_writable,
   input logic [NWAYS-1:0] line_dirty,
   input logic             rsp_valid,
   input logic             rsp_supply,
   input logic             rsp_inhibit,
   input logic             rsp_shared
);

   p_excl_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid && fill_excl && !snp_valid |=> |(line_valid & line_writable & line_dirty));

   p_shared_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid && !fill_excl && fill_shared && !snp_valid |=> |(line_valid & ~line_writable));

   p_one_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_valid && snp_valid));

   p_wb_from_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wb_req) |-> $past(fill_valid));

   p_wb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req && !wb_ack && !snp_valid |=> wb_req);

   p_flags_in_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_supply || rsp_inhibit || rsp_shared) |-> rsp_valid);

   p_perm_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((line_writable | line_dirty) & ~line_valid) == '0);

endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.NWAYS(NWAYS)) u_chk (.*);

// File: tb/coh_line_ctrl_tb.sv
`timescale 1ns/1ps
module coh_line_ctrl_tb;

   localparam int NW  = 4;
   localparam int TW  = 8;
   localparam int LAT = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          fill_valid, fill_excl, fill_shared;
   logic [TW-1:0] fill_tag;
   logic          snp_valid, snp_read, snp_inv, snp_excl;
   logic [TW-1:0] snp_tag;
   logic          wb_ack;
   logic [NW-1:0] line_valid, line_writable, line_dirty;
   logic          wb_req;
   logic [TW-1:0] wb_tag;
   logic          rsp_valid, rsp_supply, rsp_inhibit, rsp_shared;

   always #2 clk = ~clk;

   coh_line_ctrl #(.NWAYS(NW), .TAG_W(TW), .HIT_LAT(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_excl(fill_excl), .fill_shared(fill_shared),
      .snp_valid(snp_valid), .snp_tag(snp_tag), .snp_read(snp_read), .snp_inv(snp_inv), .snp_excl(snp_excl),
      .wb_ack(wb_ack),
      .line_valid(line_valid), .line_writable(line_writable), .line_dirty(line_dirty),
      .wb_req(wb_req), .wb_tag(wb_tag),
      .rsp_valid(rsp_valid), .rsp_supply(rsp_supply), .rsp_inhibit(rsp_inhibit), .rsp_shared(rsp_shared)
   );

   int n_tests = 0;
   int n_fail  = 0;

   // bench model
   logic [NW-1:0] mv, mw, md;
   logic [TW-1:0] mt [NW];
   int            mptr;
   logic          mwb;
   logic [TW-1:0] mwbt;

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_state(input string req);
      chk(line_valid == mv,    req, "line_valid",    32'(line_valid),    32'(mv));
      chk(line_writable == mw, req, "line_writable", 32'(line_writable), 32'(mw));
      chk(line_dirty == md,    req, "line_dirty",    32'(line_dirty),    32'(md));
      chk(wb_req == mwb,       req, "wb_req",        32'(wb_req),        32'(mwb));
      if (mwb) chk(wb_tag == mwbt, req, "wb_tag", 32'(wb_tag), 32'(mwbt));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      fill_valid = 0; fill_tag = '0; fill_excl = 0; fill_shared = 0;
      snp_valid = 0; snp_tag = '0; snp_read = 0; snp_inv = 0; snp_excl = 0;
      wb_ack = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      mv = '0; mw = '0; md = '0; mptr = 0; mwb = 0; mwbt = '0;
      for (int i = 0; i < NW; i++) mt[i] = '0;
   endtask

   task automatic do_fill(input logic [TW-1:0] tag, input logic ex, input logic sh, input string req);
      int way;
      way = -1;
      for (int i = 0; i < NW; i++) if (mv[i] && mt[i] == tag) way = i;
      if (way < 0) begin
         way = mptr;
         if (mv[way] && md[way]) begin mwb = 1; mwbt = mt[way]; end
         mptr = (mptr + 1) % NW;
      end
      mv[way] = 1'b1;
      mw[way] = ex || !sh;
      md[way] = ex;
      mt[way] = tag;
      fill_valid = 1; fill_tag = tag; fill_excl = ex; fill_shared = sh;
      @(posedge clk); @(negedge clk);
      fill_valid = 0; fill_excl = 0; fill_shared = 0;
      chk_state(req);
   endtask

   task automatic do_ack();
      wb_ack = 1;
      @(posedge clk); @(negedge clk);
      wb_ack = 0;
      mwb = 0;
      chk(wb_req == 1'b0, "R4", "wb_req after ack", 32'(wb_req), 32'd0);
   endtask

   task automatic do_snoop(input logic [TW-1:0] tag, input logic rd, input logic inv, input logic ex);
      int way;
      logic e_sup, e_sh;
      string sreq;
      way = -1; e_sup = 0; e_sh = 0;
      for (int i = 0; i < NW; i++) if (mv[i] && mt[i] == tag) way = i;
      if (way >= 0) begin
         e_sup = md[way] && rd;
         e_sh  = !inv;
         sreq  = inv ? "R8" : (rd ? "R7" : "R6");
         if (inv) begin mv[way] = 0; mw[way] = 0; md[way] = 0; end
         else if (rd) mw[way] = 0;
      end else if (mwb && mwbt == tag) begin
         e_sup = rd;
         e_sh  = rd && !ex;
         sreq  = "R9";
         if (inv) mwb = 0;
      end else begin
         sreq = "R5";
      end
      snp_valid = 1; snp_tag = tag; snp_read = rd; snp_inv = inv; snp_excl = ex;
      @(posedge clk); @(negedge clk);
      snp_valid = 0; snp_read = 0; snp_inv = 0; snp_excl = 0;
      chk_state(sreq);
      for (int k = 1; k < LAT; k++) begin
         chk(rsp_valid == 1'b0, "R10", "rsp_valid early", 32'(rsp_valid), 32'd0);
         @(negedge clk);
      end
      chk(rsp_valid == 1'b1, "R10", "rsp_valid at latency", 32'(rsp_valid), 32'd1);
      chk(rsp_supply == e_sup,  (sreq == "R9") ? "R9" : ((sreq == "R5") ? "R5" : "R6"),
          "rsp_supply", 32'(rsp_supply), 32'(e_sup));
      chk(rsp_inhibit == e_sup, (sreq == "R9") ? "R9" : ((sreq == "R5") ? "R5" : "R6"),
          "rsp_inhibit", 32'(rsp_inhibit), 32'(e_sup));
      chk(rsp_shared == e_sh,   (sreq == "R9") ? "R9" : ((sreq == "R5") ? "R5" : "R6"),
          "rsp_shared", 32'(rsp_shared), 32'(e_sh));
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R10", "rsp_valid pulse end", 32'(rsp_valid), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R11 reset state
      do_reset();
      chk_state("R11");
      chk(rsp_valid == 1'b0, "R11", "rsp_valid", 32'(rsp_valid), 32'd0);

      // R1 / R2 fill outcomes
      for (int k = 0; k < 3; k++) begin
         do_reset();
         do_fill(8'h10, k == 0, k == 2, (k == 0) ? "R1" : "R2");
      end

      // R6 R7 R8 R10: two back-to-back snoops against each fill outcome
      for (int k = 0; k < 3; k++) begin
         for (int s1 = 0; s1 < 8; s1++) begin
            for (int s2 = 0; s2 < 8; s2++) begin
               do_reset();
               do_fill(8'h10, k == 0, k == 2, "R2");
               do_fill(8'h20, 1'b1, 1'b0, "R1");
               do_snoop(8'h10, s1[0], s1[1], s1[2]);
               do_snoop(8'h10, s2[0], s2[1], s2[2]);
            end
         end
      end

      // R5 snoop miss leaves everything alone
      do_reset();
      do_fill(8'h30, 1'b1, 1'b0, "R1");
      do_snoop(8'h99, 1'b1, 1'b1, 1'b1);
      do_snoop(8'h99, 1'b1, 1'b0, 1'b0);

      // R3 R4 round robin, dirty eviction, in-place upgrade, clean eviction
      do_reset();
      for (int i = 0; i < NW; i++) do_fill(8'hA0 + 8'(i), 1'b1, 1'b0, "R3");
      do_fill(8'hA4, 1'b1, 1'b0, "R4");
      do_snoop(8'h55, 1'b0, 1'b0, 1'b0);
      chk(wb_req == 1'b1, "R4", "wb_req held", 32'(wb_req), 32'd1);
      do_ack();
      do_fill(8'hA1, 1'b0, 1'b1, "R3");
      do_fill(8'hA6, 1'b0, 1'b0, "R4");
      do_fill(8'hA2, 1'b0, 1'b0, "R3");
      do_fill(8'hA7, 1'b0, 1'b1, "R4");

      // R9 snoop against pending writeback
      for (int s = 0; s < 8; s++) begin
         do_reset();
         for (int i = 0; i <= NW; i++) do_fill(8'hB0 + 8'(i), 1'b1, 1'b0, "R4");
         do_snoop(8'hB0, s[0], s[1], s[2]);
         if (mwb) do_ack();
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule